// File: doc/BRIEF.md
# Register-Programmed Raster Timing Engine

This block produces the raster timing for a display output from a bank of write/read registers. A horizontal counter steps through each line, and a frame-position counter counts pixel clocks from the start of the frame. Every vertical quantity (frame length, vertical sync width, window starts and ends, sync skew) is therefore an absolute pixel-clock offset and not a line number. From the two counters the engine derives horizontal sync, vertical sync and data-enable, each with its own polarity.

Two windows shape the picture. The display window bounds the visible region. An optional narrower active window, enabled per axis, bounds where pixels from upstream are shown. Display pixels outside the active window carry a border colour. Active pixels take the upstream pixel when it is valid and an underflow colour when it is not, and a sticky flag records the underflow. A one-clock fetch pulse can be raised at a programmed frame position. Frame and line counts can be read back.

All timing registers are staged. While the engine is stopped they take effect on the next clock. While it runs they take effect only at the next frame boundary, so a frame in progress never changes shape.

Top module: `tgen_top`

## Requirements
- R1: After reset all outputs are low, `in_ready` is low, and reading the frame count (byte address 0x44) or the line count (0x48) returns zero.
- R2: While running, the horizontal counter counts 0 up to htotal−1 and wraps. The horizontal timing register (0x08) holds htotal in bits 31:16 and the sync width in bits 15:0. Raw hsync is high for counts below the sync width. Every output is registered and shows the counter state one clock later.
- R3: The frame-position counter counts 0 up to the frame length (0x0C) minus 1 and wraps. Raw vsync is high while skew (0x14) ≤ position < skew + vsync width (0x10).
- R4: The display window is the set of positions where start x ≤ hcount ≤ end x (0x18: end in bits 31:16, start in bits 15:0) and display V start (0x1C) ≤ position ≤ display V end (0x20). Without active windows, data-enable equals the display window.
- R5: Config (0x04) bit 29 enables the active horizontal window (0x24, same packing) and bit 30 enables the active vertical window (0x28 start, 0x2C end, inclusive). Data-enable additionally needs every enabled active range to hold. Display pixels without data-enable output the border colour (0x30), and pixels outside the display window output zero.
- R6: `in_ready` is high exactly in the cycles whose counter state gives data-enable. Such a cycle outputs `in_data` if `in_valid` is high. Otherwise it outputs the underflow colour (0x34) and sets the sticky `uflow` output. A write to the run register clears `uflow`, and a new underflow in the same cycle wins.
- R7: The polarity register (0x38) inverts hsync with bit 0, vsync with bit 1 and data-enable with bit 2. The same bits give the idle levels while the engine is stopped.
- R8: With config bit 31 set, `fetch` pulses for one clock for the frame position equal to the fetch-start register (0x40).
- R9: The frame count rises at each frame wrap when count-enable (0x3C) bit 0 is set. The line count rises at each horizontal wrap when bit 1 is set and clears at each frame wrap. Both read as zero while the engine is stopped.
- R10: While running, writes to registers 0x04 through 0x40 take effect at the next frame wrap. While stopped, they take effect on the next clock. Reads of those addresses return the last written value.
- R11: Run register (0x00) bit 0 starts and stops the engine. Stopping clears both counters and both counts, and starting again begins at position zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Register read data, combinational |
| in_valid | input | 1 | Upstream pixel valid |
| in_data | input | 24 | Upstream pixel colour |
| in_ready | output | 1 | Pixel taken this cycle |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable |
| pix | output | 24 | Output pixel colour |
| fetch | output | 1 | Programmable fetch pulse |
| uflow | output | 1 | Sticky underflow flag |

## Verification
The bench builds the engine with its default parameters: an 8-bit register address and 16-bit frame and line counts. It programs a tiny 10-clock by 6-line raster, so a whole frame lasts 60 clocks. At that size every output can be predicted cycle by cycle over several frames. Frame wraps, staged reloads, count rollovers, skewed vsync and polarity flips, stopping and restarting, and underflows placed inside the active window all come up within a few hundred clocks.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
    localparam int TG_HW   = 16;
    localparam int TG_FW   = 24;
    localparam int TG_CW   = 24;
    localparam int TG_DW   = 32;
    localparam int TG_NREG = 17;

    localparam int IX_RUN  = 0;
    localparam int IX_CFG  = 1;
    localparam int IX_HT   = 2;
    localparam int IX_FL   = 3;
    localparam int IX_VSW  = 4;
    localparam int IX_SKEW = 5;
    localparam int IX_DH   = 6;
    localparam int IX_DVS  = 7;
    localparam int IX_DVE  = 8;
    localparam int IX_AH   = 9;
    localparam int IX_AVS  = 10;
    localparam int IX_AVE  = 11;
    localparam int IX_BC   = 12;
    localparam int IX_UC   = 13;
    localparam int IX_POL  = 14;
    localparam int IX_CE   = 15;
    localparam int IX_FS   = 16;

    localparam int CFG_ACTH_BIT  = 29;
    localparam int CFG_ACTV_BIT  = 30;
    localparam int CFG_FETCH_BIT = 31;

    typedef struct packed {
        logic [TG_HW-1:0] htotal;
        logic [TG_HW-1:0] hsw;
        logic [TG_HW-1:0] dh_start;
        logic [TG_HW-1:0] dh_end;
        logic [TG_HW-1:0] ah_start;
        logic [TG_HW-1:0] ah_end;
        logic [TG_FW-1:0] flen;
        logic [TG_FW-1:0] vsw;
        logic [TG_FW-1:0] skew;
        logic [TG_FW-1:0] dv_start;
        logic [TG_FW-1:0] dv_end;
        logic [TG_FW-1:0] av_start;
        logic [TG_FW-1:0] av_end;
        logic [TG_FW-1:0] fstart;
        logic [TG_CW-1:0] border;
        logic [TG_CW-1:0] under;
        logic [2:0]       pol;
        logic [1:0]       cnten;
        logic             act_h_en;
        logic             act_v_en;
        logic             fetch_en;
    } tgen_cfg_t;
endpackage

// File: rtl/tgen_regs.sv
module tgen_regs
    import tgen_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [TG_DW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [TG_DW-1:0] rd_data,
    input  logic [CNT_W-1:0] frames,
    input  logic [CNT_W-1:0] lines,
    input  logic             fwrap,
    output logic             run,
    output logic             clr_sticky,
    output tgen_cfg_t        cfg
);
    localparam int IW = AW - 2;

    typedef struct packed {
        logic [TG_NREG-1:0][TG_DW-1:0] stg;
        tgen_cfg_t                     act;
    } regs_t;

    regs_t     s_d, s_q;
    tgen_cfg_t stg_cfg;
    logic      hit;
    logic      load;
    logic [IW-1:0] widx, ridx;

    assign run = s_q.stg[IX_RUN][0];
    assign cfg = s_q.act;

    always_comb begin
        stg_cfg.htotal   = s_q.stg[IX_HT][31:16];
        stg_cfg.hsw      = s_q.stg[IX_HT][15:0];
        stg_cfg.dh_end   = s_q.stg[IX_DH][31:16];
        stg_cfg.dh_start = s_q.stg[IX_DH][15:0];
        stg_cfg.ah_end   = s_q.stg[IX_AH][31:16];
        stg_cfg.ah_start = s_q.stg[IX_AH][15:0];
        stg_cfg.flen     = s_q.stg[IX_FL][TG_FW-1:0];
        stg_cfg.vsw      = s_q.stg[IX_VSW][TG_FW-1:0];
        stg_cfg.skew     = s_q.stg[IX_SKEW][TG_FW-1:0];
        stg_cfg.dv_start = s_q.stg[IX_DVS][TG_FW-1:0];
        stg_cfg.dv_end   = s_q.stg[IX_DVE][TG_FW-1:0];
        stg_cfg.av_start = s_q.stg[IX_AVS][TG_FW-1:0];
        stg_cfg.av_end   = s_q.stg[IX_AVE][TG_FW-1:0];
        stg_cfg.fstart   = s_q.stg[IX_FS][TG_FW-1:0];
        stg_cfg.border   = s_q.stg[IX_BC][TG_CW-1:0];
        stg_cfg.under    = s_q.stg[IX_UC][TG_CW-1:0];
        stg_cfg.pol      = s_q.stg[IX_POL][2:0];
        stg_cfg.cnten    = s_q.stg[IX_CE][1:0];
        stg_cfg.act_h_en = s_q.stg[IX_CFG][CFG_ACTH_BIT];
        stg_cfg.act_v_en = s_q.stg[IX_CFG][CFG_ACTV_BIT];
        stg_cfg.fetch_en = s_q.stg[IX_CFG][CFG_FETCH_BIT];
    end

    always_comb begin
        s_d  = s_q;
        widx = wr_addr[AW-1:2];
        hit  = wr_en && (wr_addr[1:0] == 2'b00) && (int'(widx) < TG_NREG);
        load = !run || fwrap;
        if (load) s_d.act = stg_cfg;
        if (hit) s_d.stg[widx] = wr_data;
        clr_sticky = hit && (int'(widx) == IX_RUN);
    end

    always_comb begin
        ridx    = rd_addr[AW-1:2];
        rd_data = '0;
        if (rd_addr[1:0] == 2'b00) begin
            if (int'(ridx) < TG_NREG)
                rd_data = s_q.stg[ridx];
            else if (int'(ridx) == TG_NREG)
                rd_data = run ? TG_DW'(frames) : '0;
            else if (int'(ridx) == TG_NREG + 1)
                rd_data = run ? TG_DW'(lines) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |=> $stable(s_q.act)); // R10

endmodule

// File: rtl/tgen_cnt.sv
module tgen_cnt
    import tgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  tgen_cfg_t        cfg,
    output logic [TG_HW-1:0] hcnt,
    output logic [TG_FW-1:0] fpos,
    output logic             fwrap,
    output logic [CNT_W-1:0] frames,
    output logic [CNT_W-1:0] lines
);
    typedef struct packed {
        logic [TG_HW-1:0] h;
        logic [TG_FW-1:0] f;
        logic [CNT_W-1:0] frames;
        logic [CNT_W-1:0] lines;
    } cnt_t;

    cnt_t c_d, c_q;
    logic hwrap;

    assign hcnt   = c_q.h;
    assign fpos   = c_q.f;
    assign frames = c_q.frames;
    assign lines  = c_q.lines;

    always_comb begin
        hwrap = run && (c_q.h == cfg.htotal - 1'b1);
        fwrap = run && (c_q.f == cfg.flen - 1'b1);
        c_d   = c_q;
        if (!run) begin
            c_d = '0;
        end else begin
            c_d.h = hwrap ? '0 : c_q.h + 1'b1;
            c_d.f = fwrap ? '0 : c_q.f + 1'b1;
            if (fwrap) begin
                c_d.lines = '0;
                if (cfg.cnten[0]) c_d.frames = c_q.frames + 1'b1;
            end else if (hwrap && cfg.cnten[1]) begin
                c_d.lines = c_q.lines + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!run && $past(!run)) |-> (c_q.h == '0 && c_q.f == '0)); // R11

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |->
        (c_q.frames == $past(c_q.frames) || c_q.frames == $past(c_q.frames) + 1'b1)); // R9

    AST_LINES_CLEAR: assert property (@(posedge clk) disable iff (rst)
        fwrap |=> (c_q.lines == '0)); // R9

endmodule

// File: rtl/tgen_pix.sv
module tgen_pix
    import tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  tgen_cfg_t        cfg,
    input  logic [TG_HW-1:0] hcnt,
    input  logic [TG_FW-1:0] fpos,
    input  logic             in_valid,
    input  logic [TG_CW-1:0] in_data,
    input  logic             clr_sticky,
    output logic             in_ready,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [TG_CW-1:0] pix,
    output logic             fetch,
    output logic             uflow
);
    typedef struct packed {
        logic [2:0]       sync;
        logic [TG_CW-1:0] pix;
        logic             fetch;
        logic             uflow;
    } out_t;

    out_t o_d, o_q;
    logic [TG_FW:0] vs_end;
    logic [2:0] raw;
    logic disp_h, disp_v, act_h, act_v, in_disp, de_raw;

    always_comb begin
        vs_end  = {1'b0, cfg.skew} + {1'b0, cfg.vsw};
        disp_h  = (hcnt >= cfg.dh_start) && (hcnt <= cfg.dh_end);
        disp_v  = (fpos >= cfg.dv_start) && (fpos <= cfg.dv_end);
        act_h   = !cfg.act_h_en || ((hcnt >= cfg.ah_start) && (hcnt <= cfg.ah_end));
        act_v   = !cfg.act_v_en || ((fpos >= cfg.av_start) && (fpos <= cfg.av_end));
        in_disp = disp_h && disp_v;
        de_raw  = run && in_disp && act_h && act_v;
        raw[0]  = hcnt < cfg.hsw;
        raw[1]  = ({1'b0, fpos} >= {1'b0, cfg.skew}) && ({1'b0, fpos} < vs_end);
        raw[2]  = de_raw;
        in_ready = de_raw;

        o_d = o_q;
        if (clr_sticky) o_d.uflow = 1'b0;
        if (run) begin
            o_d.sync  = raw ^ cfg.pol;
            o_d.fetch = cfg.fetch_en && (fpos == cfg.fstart);
            if (de_raw) begin
                if (in_valid) begin
                    o_d.pix = in_data;
                end else begin
                    o_d.pix   = cfg.under;
                    o_d.uflow = 1'b1;
                end
            end else if (in_disp) begin
                o_d.pix = cfg.border;
            end else begin
                o_d.pix = '0;
            end
        end else begin
            o_d.sync  = cfg.pol;
            o_d.fetch = 1'b0;
            o_d.pix   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign hsync = o_q.sync[0];
    assign vsync = o_q.sync[1];
    assign de    = o_q.sync[2];
    assign pix   = o_q.pix;
    assign fetch = o_q.fetch;
    assign uflow = o_q.uflow;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (uflow && !clr_sticky) |=> uflow); // R6

    AST_DE_TRACKS_READY: assert property (@(posedge clk) disable iff (rst)
        $past(run) |-> ((de ^ $past(cfg.pol[2])) == $past(in_ready))); // R6

    AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> !fetch); // R8

    AST_UNDER_COLOUR: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (uflow && pix == $past(cfg.under))); // R6

endmodule

// File: rtl/tgen_top.sv
module tgen_top
    import tgen_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [TG_DW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [TG_DW-1:0] rd_data,
    input  logic             in_valid,
    input  logic [TG_CW-1:0] in_data,
    output logic             in_ready,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [TG_CW-1:0] pix,
    output logic             fetch,
    output logic             uflow
);
    tgen_cfg_t        cfg;
    logic             run, clr_sticky, fwrap;
    logic [TG_HW-1:0] hcnt;
    logic [TG_FW-1:0] fpos;
    logic [CNT_W-1:0] frames, lines;

    tgen_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frames(frames), .lines(lines),
        .fwrap(fwrap), .run(run), .clr_sticky(clr_sticky), .cfg(cfg)
    );

    tgen_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .cfg(cfg), .hcnt(hcnt), .fpos(fpos),
        .fwrap(fwrap), .frames(frames), .lines(lines)
    );

    tgen_pix u_pix (
        .clk(clk), .rst(rst), .run(run), .cfg(cfg), .hcnt(hcnt), .fpos(fpos),
        .in_valid(in_valid), .in_data(in_data), .clr_sticky(clr_sticky),
        .in_ready(in_ready), .hsync(hsync), .vsync(vsync), .de(de), .pix(pix),
        .fetch(fetch), .uflow(uflow)
    );

endmodule

// File: tb/sim_tgen_top.sv
module sim_tgen_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        in_ready, hsync, vsync, de, fetch, uflow;
    logic [23:0] pix;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic hs, vs, de, fetch, uflow;
        logic [23:0] pix;
        string tag;
    } exp_t;

    exp_t q[$];

    logic [31:0] st [0:16];
    logic [31:0] ac [0:16];
    bit running = 0;
    bit m_uflow = 0;
    int unsigned mh = 0, mf = 0, m_frames = 0, m_lines = 0;
    string phase = "R2";

    tgen_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .hsync(hsync), .vsync(vsync), .de(de), .pix(pix),
        .fetch(fetch), .uflow(uflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check1(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // expected outputs for a counter state, from the requirements
    task automatic model(input int unsigned h, input int unsigned f, input bit v,
                         input logic [23:0] pd, output exp_t e, output bit de_raw);
        logic [31:0] ht_sw, vsw, sk, dvs, dve, avs, ave, fs;
        bit rh, rv, dh, dv, ah, av, ind;
        ht_sw = ac[2];
        vsw = ac[4] & 32'hFFFFFF; sk = ac[5] & 32'hFFFFFF;
        dvs = ac[7] & 32'hFFFFFF; dve = ac[8] & 32'hFFFFFF;
        avs = ac[10] & 32'hFFFFFF; ave = ac[11] & 32'hFFFFFF;
        fs = ac[16] & 32'hFFFFFF;
        e.tag = phase;
        e.uflow = m_uflow;
        if (!running) begin
            de_raw = 0;
            e.hs = ac[14][0]; e.vs = ac[14][1]; e.de = ac[14][2];
            e.pix = '0; e.fetch = 0;
            return;
        end
        rh  = h < ht_sw[15:0];
        rv  = (f >= sk) && (f < sk + vsw);
        dh  = (h >= ac[6][15:0]) && (h <= ac[6][31:16]);
        dv  = (f >= dvs) && (f <= dve);
        ah  = !ac[1][29] || ((h >= ac[9][15:0]) && (h <= ac[9][31:16]));
        av  = !ac[1][30] || ((f >= avs) && (f <= ave));
        ind = dh && dv;
        de_raw = ind && ah && av;
        e.hs = rh ^ ac[14][0];
        e.vs = rv ^ ac[14][1];
        e.de = de_raw ^ ac[14][2];
        e.fetch = ac[1][31] && (f == fs);
        if (de_raw) e.pix = v ? pd : ac[13][23:0];
        else if (ind) e.pix = ac[12][23:0];
        else e.pix = '0;
        if (de_raw && !v) e.uflow = 1;
    endtask

    // one clock: drive, predict, then advance the reference state
    task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d,
                        input bit v, input logic [23:0] pd);
        exp_t e;
        bit de_raw, wh, wf;
        int unsigned ht, fl;
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; in_valid = v; in_data = pd;
        model(mh, mf, v, pd, e, de_raw);
        if (w && a == 8'h00 && !(de_raw && !v)) e.uflow = 0;
        #1;
        check1("R6 in_ready", {31'd0, in_ready}, {31'd0, de_raw});
        @(posedge clk);
        #1;
        wr_en = 0; in_valid = 0;
        q.push_back(e);
        m_uflow = e.uflow;
        ht = ac[2][31:16];
        fl = ac[3] & 32'hFFFFFF;
        wh = running && (mh == ht - 1);
        wf = running && (mf == fl - 1);
        if (running) begin
            if (wf) begin
                m_lines = 0;
                if (ac[15][0]) m_frames++;
            end else if (wh && ac[15][1]) m_lines++;
            mh = wh ? 0 : mh + 1;
            mf = wf ? 0 : mf + 1;
        end else begin
            mh = 0; mf = 0; m_frames = 0; m_lines = 0;
        end
        if (!running || wf) for (int i = 0; i < 17; i++) ac[i] = st[i];
        if (w && a[1:0] == 2'b00 && a[7:2] < 17) st[a[7:2]] = d;
        running = st[0][0];
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1, a, d, 0, '0);
    endtask

    task automatic run_n(input int n, input int w_at, input logic [7:0] a,
                         input logic [31:0] d, input int gap);
        for (int i = 0; i < n; i++) begin
            bit v;
            v = (gap == 0) || ((i % gap) != 3);
            step(i == w_at, a, d, v, 24'((i * 37 + 5) & 32'hFFFFFF));
        end
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check1(tag, rd_data, exp);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check1({e.tag, "/R2 hsync"}, {31'd0, hsync}, {31'd0, e.hs});
            check1({e.tag, "/R3 vsync"}, {31'd0, vsync}, {31'd0, e.vs});
            check1({e.tag, "/R4 de"}, {31'd0, de}, {31'd0, e.de});
            check1({e.tag, "/R5 pix"}, {8'd0, pix}, {8'd0, e.pix});
            check1({e.tag, "/R8 fetch"}, {31'd0, fetch}, {31'd0, e.fetch});
            check1({e.tag, "/R6 uflow"}, {31'd0, uflow}, {31'd0, e.uflow});
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 17; i++) begin st[i] = '0; ac[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check1("R1 hsync", {31'd0, hsync}, 0);
        check1("R1 vsync", {31'd0, vsync}, 0);
        check1("R1 de", {31'd0, de}, 0);
        check1("R1 pix", {8'd0, pix}, 0);
        check1("R1 ready", {31'd0, in_ready}, 0);
        check1("R1 uflow", {31'd0, uflow}, 0);
        rd_check("R1 frames", 8'h44, 0);
        rd_check("R1 lines", 8'h48, 0);

        // raster 10 clocks x 6 lines
        wr(8'h08, (32'd10 << 16) | 32'd2);
        wr(8'h0C, 32'd60);
        wr(8'h10, 32'd10);
        wr(8'h14, 32'd0);
        wr(8'h18, (32'd8 << 16) | 32'd4);
        wr(8'h1C, 32'd20);
        wr(8'h20, 32'd49);
        wr(8'h24, (32'd7 << 16) | 32'd5);
        wr(8'h28, 32'd30);
        wr(8'h2C, 32'd39);
        wr(8'h30, 32'h00B0B0B0);
        wr(8'h34, 32'h00EE0000);
        wr(8'h38, 32'd0);
        wr(8'h3C, 32'd3);
        wr(8'h40, 32'd55);
        wr(8'h04, 32'd0);
        rd_check("R10 readback", 8'h18, (32'd8 << 16) | 32'd4);

        // R11 start, R2 R3 R4 plain display window
        phase = "R11";
        wr(8'h00, 32'd1);
        phase = "R4";
        run_n(130, -1, 8'h00, 0, 0);
        rd_check("R9 frames", 8'h44, m_frames);
        rd_check("R9 lines", 8'h48, m_lines);
        check1("R9 frames model", m_frames, 2);

        // R10 staged config: windows and fetch enabled mid-frame
        phase = "R10";
        run_n(40, 5, 8'h04, 32'hE000_0000, 0);
        rd_check("R10 readback cfg", 8'h04, 32'hE000_0000);
        run_n(40, 3, 8'h30, 32'h0012_3456, 0);

        // R5 R6 R8 active window with underflows
        phase = "R6";
        run_n(130, -1, 8'h00, 0, 7);
        check1("R6 sticky set", {31'd0, uflow}, 1);

        // R7 polarity flip, R3 skewed vsync
        phase = "R7";
        run_n(130, 10, 8'h38, 32'd7, 0);
        phase = "R3";
        run_n(130, 12, 8'h14, 32'd3, 0);

        // R11 stop: counts read zero, idle levels
        phase = "R11";
        wr(8'h00, 32'd0);
        rd_check("R9 frames stopped", 8'h44, 0);
        rd_check("R9 lines stopped", 8'h48, 0);
        run_n(5, -1, 8'h00, 0, 0);
        wr(8'h3C, 32'd1);
        wr(8'h38, 32'd0);
        wr(8'h00, 32'd1);
        check1("R6 sticky cleared", {31'd0, uflow}, 0);
        run_n(135, -1, 8'h00, 0, 0);
        rd_check("R11 frames restart", 8'h44, m_frames);
        rd_check("R9 lines gated", 8'h48, 0);
        check1("R11 frames model", m_frames, 2);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule